// File: doc/BRIEF.md
# Final-Block Message Padder

This unit sits between a word-wide message input and the 512-bit compression engine of a SHA-1 / SHA-2 style hash. Message words arrive one per write in big-endian bit-string order. The unit forwards them as a stream of 16-word blocks. When it receives a final-calculation command, it closes the message with the standard padding. The padding is a single marker 1 right after the last valid message bit, zeros up to bit 448 of a block, and the 64-bit message length in bits.

The last word of a message may be partial. A separately written valid-bit count gives the number of leading valid bits of that word, and a count of zero means the whole word is valid. The unit holds back the newest word until it knows whether another word follows, so it can close that word in place. The unit keeps its own word counter and derives the message length from that counter and the valid-bit count, so no length input is needed. When the marker leaves no room for the two length words, the unit emits one more block that is zero except for the length.

Top module: `mpad_final_block`

## Requirements
- R1: After reset or an `init_i` pulse, `busy_o` and `out_valid_o` are low. The word counter and the valid-bit count are cleared to 0. `init_i` also aborts padding that is in progress.
- R2: Message words leave unchanged and in order. A word is emitted one cycle after the next message word is accepted. `out_last_o` marks the word in block slot 15, where slots are numbered from 0 in emission order.
- R3: For a count n from 1 to 31, the final word keeps its n most significant bits. Bit 31-n is set and all lower bits are cleared. For example, 0x616263AA with n = 24 becomes 0x61626380.
- R4: For a count of 0, the final word is emitted unchanged and is followed by the marker word 0x80000000.
- R5: Zero words fill the block after the marker until slot 14. Slot 14 carries length bits 63:32 and slot 15 carries length bits 31:0. `out_final_o` is high on the slot-15 length word only.
- R6: The length equals 32*(W-1) plus the effective count, where W is the number of words accepted since init or since the last completed message. The effective count is 32 when n is 0 and n otherwise. A message with no words has length 0 and is emitted as the marker word 0x80000000 followed by zeros and the length.
- R7: When the marker-bearing word falls in slot 14 or 15, an extra block follows. It holds only zeros and the length words.
- R8: `final_i` is ignored in a cycle that also asserts `nvb_wr_i` or `din_valid_i`. The count write or the data word is still taken in that cycle.
- R9: Padding starts in the cycle after an accepted command and runs one word per cycle. While `busy_o` is high, `din_valid_i`, `nvb_wr_i` and `final_i` are ignored.
- R10: The valid-bit count keeps its last written value across completed messages until `init_i`. Each completed message restarts the word counter at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Clears all state and aborts padding |
| din_valid_i | input | 1 | Message word present on `din_i` |
| din_i | input | 32 | Message word, big-endian bit-string order |
| nvb_wr_i | input | 1 | Writes `nvb_i` into the valid-bit count |
| nvb_i | input | 5 | Valid bits in the final word (0 means 32) |
| final_i | input | 1 | Final-calculation command |
| busy_o | output | 1 | Padding sequence in progress |
| out_valid_o | output | 1 | `out_word_o` carries a block word |
| out_word_o | output | 32 | Block word toward the compression engine |
| out_last_o | output | 1 | Word occupies block slot 15 |
| out_final_o | output | 1 | Last word of the padded message |

## Verification
Two functions can fall in the same cycle. The final command can coincide with a count write, and it can also coincide with a data word. The bench drives both combinations together. It then judges the result at the ports. `busy_o` must stay low and no padding words may appear. The count or word must still be taken. A later lone command must pad using the count written in that shared cycle and must include the extra word. A further case sends data words, count writes and commands while padding runs, and the resulting block and the next message's length show that none of them took effect.

// File: rtl/mpad_pkg.sv
package mpad_pkg;

    localparam int unsigned MP_WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLOSE  = 3'd1,
        ST_MARK   = 3'd2,
        ST_ZERO   = 3'd3,
        ST_LEN_HI = 3'd4,
        ST_LEN_LO = 3'd5
    } pad_state_e;

endpackage

// File: rtl/mpad_close.sv
// Closes the final message word: keeps the leading valid bits, sets the
// marker right after them and clears the rest. A count of zero passes the
// word through unchanged (all bits valid).
module mpad_close #(
    parameter int unsigned WORD_W = mpad_pkg::MP_WORD_W,
    localparam int unsigned CB = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [CB-1:0]     nvb_i,
    output logic [WORD_W-1:0] word_o
);
    logic all_valid;
    assign all_valid = (nvb_i == '0);

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        // position of this bit in the big-endian bit string
        localparam logic [CB-1:0] SPOS = CB'(WORD_W - 1 - b);
        logic keep;
        logic mark;
        assign keep = (SPOS < nvb_i);
        assign mark = (SPOS == nvb_i);
        assign word_o[b] = all_valid ? word_i[b] : ((keep & word_i[b]) | mark);
    end
endmodule

// File: rtl/mpad_lenctr.sv
// Counts accepted message words, stores the valid-bit count and derives
// the message length in bits.
module mpad_lenctr #(
    parameter int unsigned WORD_W = mpad_pkg::MP_WORD_W,
    parameter int unsigned LEN_W  = 64,
    localparam int unsigned LB    = $clog2(WORD_W),
    localparam int unsigned CNT_W = LEN_W - LB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             done_i,
    input  logic             inc_i,
    input  logic             nvb_wr_i,
    input  logic [LB-1:0]    nvb_i,
    output logic [LB-1:0]    nvb_o,
    output logic [LEN_W-1:0] len_o
);
    typedef struct packed {
        logic [CNT_W-1:0] wcnt;
        logic [LB-1:0]    nvb;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (nvb_wr_i) c_d.nvb  = nvb_i;
        if (inc_i)    c_d.wcnt = c_q.wcnt + CNT_W'(1);
        if (done_i)   c_d.wcnt = '0;
        if (init_i)   c_d      = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic [CNT_W-1:0] wcnt_m1;
    logic [LEN_W-1:0] eff_bits;
    assign wcnt_m1  = c_q.wcnt - CNT_W'(1);
    assign eff_bits = (c_q.nvb == '0) ? LEN_W'(WORD_W) : LEN_W'(c_q.nvb);
    assign len_o    = (c_q.wcnt == '0) ? '0 : ({wcnt_m1, {LB{1'b0}}} + eff_bits);
    assign nvb_o    = c_q.nvb;
endmodule

// File: rtl/mpad_seq.sv
// Word hold register, block slot counter and padding sequencer with
// registered output stream.
module mpad_seq
    import mpad_pkg::*;
#(
    parameter int unsigned WORD_W    = MP_WORD_W,
    parameter int unsigned BLK_WORDS = 16,
    parameter int unsigned LEN_W     = 64,
    localparam int unsigned POS_W    = $clog2(BLK_WORDS),
    localparam int unsigned LEN_SLOT = BLK_WORDS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              din_valid_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              final_i,
    input  logic              nvb_wr_i,
    input  logic              nvb_zero_i,
    input  logic [WORD_W-1:0] closed_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [WORD_W-1:0] held_o,
    output logic              accept_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_word_o,
    output logic              out_last_o,
    output logic              out_final_o
);
    localparam logic [WORD_W-1:0] MARK_WORD = {1'b1, {(WORD_W-1){1'b0}}};

    typedef struct packed {
        pad_state_e        st;
        logic [WORD_W-1:0] held;
        logic              held_v;
        logic [POS_W-1:0]  pos;
        logic              ov;
        logic [WORD_W-1:0] ow;
        logic              olast;
        logic              ofinal;
    } seq_t;

    seq_t s_d, s_q;

    logic [POS_W-1:0]  pos_n;
    pad_state_e        after_mark;
    logic              emit;
    logic [WORD_W-1:0] emit_word;

    assign pos_n      = s_q.pos + POS_W'(1);
    assign after_mark = (pos_n == POS_W'(LEN_SLOT)) ? ST_LEN_HI : ST_ZERO;

    always_comb begin
        s_d        = s_q;
        s_d.ov     = 1'b0;
        s_d.olast  = 1'b0;
        s_d.ofinal = 1'b0;
        emit       = 1'b0;
        emit_word  = '0;
        accept_o   = 1'b0;
        done_o     = 1'b0;

        unique case (s_q.st)
            ST_IDLE: begin
                if (din_valid_i) begin
                    accept_o   = 1'b1;
                    s_d.held   = din_i;
                    s_d.held_v = 1'b1;
                    if (s_q.held_v) begin
                        emit      = 1'b1;
                        emit_word = s_q.held;
                    end
                end else if (final_i && !nvb_wr_i) begin
                    s_d.st = s_q.held_v ? ST_CLOSE : ST_MARK;
                end
            end
            ST_CLOSE: begin
                emit       = 1'b1;
                emit_word  = closed_i;
                s_d.held_v = 1'b0;
                s_d.st     = nvb_zero_i ? ST_MARK : after_mark;
            end
            ST_MARK: begin
                emit      = 1'b1;
                emit_word = MARK_WORD;
                s_d.st    = after_mark;
            end
            ST_ZERO: begin
                emit      = 1'b1;
                emit_word = '0;
                s_d.st    = (pos_n == POS_W'(LEN_SLOT)) ? ST_LEN_HI : ST_ZERO;
            end
            ST_LEN_HI: begin
                emit      = 1'b1;
                emit_word = len_i[LEN_W-1 -: WORD_W];
                s_d.st    = ST_LEN_LO;
            end
            ST_LEN_LO: begin
                emit       = 1'b1;
                emit_word  = len_i[WORD_W-1:0];
                s_d.ofinal = 1'b1;
                done_o     = 1'b1;
                s_d.st     = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (emit) begin
            s_d.ov    = 1'b1;
            s_d.ow    = emit_word;
            s_d.olast = (s_q.pos == POS_W'(BLK_WORDS - 1));
            s_d.pos   = pos_n;
        end

        if (init_i) begin
            s_d      = '0;
            accept_o = 1'b0;
            done_o   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held_o      = s_q.held;
    assign busy_o      = (s_q.st != ST_IDLE);
    assign out_valid_o = s_q.ov;
    assign out_word_o  = s_q.ow;
    assign out_last_o  = s_q.olast;
    assign out_final_o = s_q.ofinal;
endmodule

// File: rtl/mpad_final_block.sv
module mpad_final_block #(
    parameter int unsigned WORD_W    = mpad_pkg::MP_WORD_W,
    parameter int unsigned BLK_WORDS = 16,
    parameter int unsigned LEN_W     = 2 * WORD_W,
    localparam int unsigned LB       = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              din_valid_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic              nvb_wr_i,
    input  logic [LB-1:0]     nvb_i,
    input  logic              final_i,
    output logic              busy_o,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_word_o,
    output logic              out_last_o,
    output logic              out_final_o
);
    logic [WORD_W-1:0] held;
    logic [WORD_W-1:0] closed;
    logic [LB-1:0]     nvb_q;
    logic [LEN_W-1:0]  msg_len;
    logic              accept;
    logic              done;
    logic              busy;
    logic              nvb_wr_ok;

    assign nvb_wr_ok = nvb_wr_i & ~busy;
    assign busy_o    = busy;

    mpad_lenctr #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (init_i),
        .done_i   (done),
        .inc_i    (accept),
        .nvb_wr_i (nvb_wr_ok),
        .nvb_i    (nvb_i),
        .nvb_o    (nvb_q),
        .len_o    (msg_len)
    );

    mpad_close #(.WORD_W(WORD_W)) u_close (
        .word_i (held),
        .nvb_i  (nvb_q),
        .word_o (closed)
    );

    mpad_seq #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .din_valid_i (din_valid_i),
        .din_i       (din_i),
        .final_i     (final_i),
        .nvb_wr_i    (nvb_wr_i),
        .nvb_zero_i  (nvb_q == '0),
        .closed_i    (closed),
        .len_i       (msg_len),
        .held_o      (held),
        .accept_o    (accept),
        .done_o      (done),
        .busy_o      (busy),
        .out_valid_o (out_valid_o),
        .out_word_o  (out_word_o),
        .out_last_o  (out_last_o),
        .out_final_o (out_final_o)
    );
endmodule

// File: rtl/mpad_chk.sv
module mpad_chk #(
    parameter int unsigned BLK_WORDS = 16,
    localparam int unsigned POS_W    = $clog2(BLK_WORDS)
) (
    input logic clk,
    input logic rst_n,
    input logic init_i,
    input logic din_valid_i,
    input logic nvb_wr_i,
    input logic final_i,
    input logic busy_o,
    input logic out_valid_o,
    input logic out_last_o,
    input logic out_final_o
);
    logic [POS_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           slot_q <= '0;
        else if (init_i)      slot_q <= '0;
        else if (out_valid_o) slot_q <= slot_q + POS_W'(1);
    end

    // R1
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!busy_o && !out_valid_o));

    // R2
    last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_last_o) |-> (slot_q == POS_W'(BLK_WORDS - 1)));

    // R2
    slot_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && slot_q == POS_W'(BLK_WORDS - 1)) |-> out_last_o);

    // R5
    final_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_final_o |-> (out_valid_o && out_last_o && !busy_o));

    // R8
    start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(final_i) && !$past(nvb_wr_i) && !$past(din_valid_i)));

    // R9
    pad_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !init_i) |=> out_valid_o);

    // R5
    end_on_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(init_i)) |-> out_final_o);
endmodule

bind mpad_final_block mpad_chk #(.BLK_WORDS(BLK_WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .din_valid_i (din_valid_i),
    .nvb_wr_i    (nvb_wr_i),
    .final_i     (final_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .out_final_o (out_final_o)
);

// File: tb/mpad_final_block_tb.sv
module mpad_final_block_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        init_i, din_valid_i, nvb_wr_i, final_i;
    logic [31:0] din_i;
    logic [4:0]  nvb_i;
    logic        busy_o, out_valid_o, out_last_o, out_final_o;
    logic [31:0] out_word_o;

    always #4 clk = ~clk;

    mpad_final_block u_dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .din_valid_i(din_valid_i),
        .din_i(din_i), .nvb_wr_i(nvb_wr_i), .nvb_i(nvb_i), .final_i(final_i),
        .busy_o(busy_o), .out_valid_o(out_valid_o), .out_word_o(out_word_o),
        .out_last_o(out_last_o), .out_final_o(out_final_o)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] msg   [0:31];
    logic [31:0] exp_w [0:63];
    int          exp_n;
    logic [31:0] cap_w [0:63];
    logic        cap_l [0:63];
    logic        cap_f [0:63];
    int          cap_n = 0;
    bit          seen_final = 0;

    // capture output stream away from both clock edges
    always begin
        @(posedge clk);
        #2;
        if (out_valid_o) begin
            if (cap_n < 64) begin
                cap_w[cap_n] = out_word_o;
                cap_l[cap_n] = out_last_o;
                cap_f[cap_n] = out_final_o;
            end
            cap_n++;
            if (out_final_o) seen_final = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clear_cap();
        cap_n = 0;
        seen_final = 0;
    endtask

    task automatic send_word(input logic [31:0] w);
        din_valid_i = 1'b1; din_i = w;
        @(negedge clk);
        din_valid_i = 1'b0;
    endtask

    task automatic set_nvb(input int n);
        nvb_wr_i = 1'b1; nvb_i = n[4:0];
        @(negedge clk);
        nvb_wr_i = 1'b0;
    endtask

    task automatic fire_final();
        final_i = 1'b1;
        @(negedge clk);
        final_i = 1'b0;
    endtask

    task automatic pulse_init();
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
    endtask

    task automatic wait_final();
        for (int k = 0; k < 100 && !seen_final; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic build_exp(input int nw, input int n);
        logic [63:0] len_bits;
        exp_n = 0;
        for (int i = 0; i < nw - 1; i++) begin exp_w[exp_n] = msg[i]; exp_n++; end
        if (nw == 0) begin
            exp_w[exp_n] = 32'h8000_0000; exp_n++;
        end else if (n == 0) begin
            exp_w[exp_n] = msg[nw-1]; exp_n++;
            exp_w[exp_n] = 32'h8000_0000; exp_n++;
        end else begin
            exp_w[exp_n] = (msg[nw-1] & ~(32'hFFFF_FFFF >> n)) | (32'h8000_0000 >> n);
            exp_n++;
        end
        while ((exp_n % 16) != 14) begin exp_w[exp_n] = '0; exp_n++; end
        len_bits = (nw == 0) ? 64'd0 : 64'(nw - 1) * 64'd32 + 64'((n == 0) ? 32 : n);
        exp_w[exp_n] = len_bits[63:32]; exp_n++;
        exp_w[exp_n] = len_bits[31:0];  exp_n++;
    endtask

    task automatic compare_run(input string req);
        chk(cap_n == exp_n, {req, " word count"}, 64'(cap_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_w[i] == exp_w[i], {req, " word"}, 64'(cap_w[i]), 64'(exp_w[i]));
            chk(cap_l[i] == ((i % 16) == 15), {req, " R2 slot-15 flag"}, 64'(cap_l[i]), 64'((i % 16) == 15));
            chk(cap_f[i] == (i == exp_n - 1), {req, " R5 final flag"}, 64'(cap_f[i]), 64'(i == exp_n - 1));
        end
    endtask

    task automatic run_msg(input int nw, input int n, input bit wr_nvb, input string req);
        clear_cap();
        for (int i = 0; i < nw; i++) send_word(msg[i]);
        if (wr_nvb) set_nvb(n);
        fire_final();
        wait_final();
        build_exp(nw, n);
        compare_run(req);
    endtask

    task automatic fill_msg(input logic [31:0] seed);
        for (int i = 0; i < 32; i++) msg[i] = seed + 32'(i) * 32'h0101_0101;
    endtask

    task automatic t_reset();
        chk(busy_o == 1'b0, "R1 busy after reset", 64'(busy_o), 0);
        chk(out_valid_o == 1'b0, "R1 valid after reset", 64'(out_valid_o), 0);
    endtask

    task automatic t_abc();
        msg[0] = 32'h6162_63AA;
        run_msg(1, 24, 1, "R3 R5 R6 abc");
        chk(cap_w[0] == 32'h6162_6380, "R3 abc marker word", 64'(cap_w[0]), 64'h6162_6380);
        chk(cap_w[15] == 32'h18, "R6 abc length", 64'(cap_w[15]), 64'h18);
    endtask

    task automatic t_full_14();
        fill_msg(32'h1020_3040);
        run_msg(14, 0, 1, "R4 R7 fourteen full");
        chk(cap_w[14] == 32'h8000_0000, "R4 marker word", 64'(cap_w[14]), 64'h8000_0000);
        chk(cap_w[31] == 32'h1C0, "R7 extra-block length", 64'(cap_w[31]), 64'h1C0);
    endtask

    task automatic t_partial_14();
        fill_msg(32'hC0DE_0001);
        run_msg(14, 8, 1, "R5 marker then length");
    endtask

    task automatic t_partial_15();
        fill_msg(32'h0BAD_F00D);
        run_msg(15, 31, 1, "R7 marker in slot 14");
    endtask

    task automatic t_full_16();
        fill_msg(32'h7777_0000);
        run_msg(16, 0, 1, "R4 R6 block-aligned");
    endtask

    task automatic t_empty();
        run_msg(0, 0, 1, "R6 empty message");
    endtask

    task automatic t_same_cycle();
        fill_msg(32'h5500_AA00);
        clear_cap();
        for (int i = 0; i < 3; i++) send_word(msg[i]);
        nvb_wr_i = 1'b1; nvb_i = 5'd16; final_i = 1'b1;
        @(negedge clk);
        nvb_wr_i = 1'b0; final_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy_o == 1'b0, "R8 final with count write ignored", 64'(busy_o), 0);
        chk(cap_n == 2, "R8 no padding emitted", 64'(cap_n), 2);
        din_valid_i = 1'b1; din_i = msg[3]; final_i = 1'b1;
        @(negedge clk);
        din_valid_i = 1'b0; final_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(busy_o == 1'b0, "R8 final with data ignored", 64'(busy_o), 0);
        chk(cap_n == 3, "R8 data word still taken", 64'(cap_n), 3);
        fire_final();
        wait_final();
        build_exp(4, 16);
        compare_run("R8 count from shared cycle");
    endtask

    task automatic t_busy_ignore();
        fill_msg(32'h3141_5926);
        clear_cap();
        send_word(msg[0]);
        send_word(msg[1]);
        set_nvb(12);
        fire_final();
        for (int k = 0; k < 4; k++) begin
            din_valid_i = 1'b1; din_i = 32'hDEAD_0000 + 32'(k);
            final_i = 1'b1; nvb_wr_i = 1'b1; nvb_i = 5'd5;
            @(negedge clk);
        end
        din_valid_i = 1'b0; final_i = 1'b0; nvb_wr_i = 1'b0;
        wait_final();
        build_exp(2, 12);
        compare_run("R9 inputs ignored while busy");
        msg[0] = 32'h0F0F_0F0F;
        run_msg(1, 12, 0, "R10 count kept, counter restarted");
    endtask

    task automatic t_init();
        fill_msg(32'h2222_0000);
        clear_cap();
        for (int i = 0; i < 3; i++) send_word(msg[i]);
        set_nvb(7);
        pulse_init();
        chk(busy_o == 1'b0, "R1 busy after init", 64'(busy_o), 0);
        msg[0] = 32'h1234_5678;
        run_msg(1, 0, 0, "R1 state cleared by init");
        clear_cap();
        send_word(32'hABCD_0001);
        send_word(32'hABCD_0002);
        fire_final();
        repeat (3) @(negedge clk);
        pulse_init();
        chk(busy_o == 1'b0, "R1 init aborts padding busy", 64'(busy_o), 0);
        chk(out_valid_o == 1'b0, "R1 init aborts padding valid", 64'(out_valid_o), 0);
        msg[0] = 32'h6162_63AA;
        run_msg(1, 24, 1, "R1 clean restart after abort");
    endtask

    task automatic run_all();
        t_reset();
        t_abc();
        t_full_14();
        t_partial_14();
        t_partial_15();
        t_full_16();
        t_empty();
        t_same_cycle();
        t_busy_ignore();
        t_init();
    endtask

    initial begin
        rst_n = 1'b0; init_i = 1'b0; din_valid_i = 1'b0; nvb_wr_i = 1'b0;
        final_i = 1'b0; din_i = '0; nvb_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL R1 watchdog expired: actual hung expected done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule